// File: doc/BRIEF.md
# Low-Power and Emulation Mode Controller

This block tracks the operating mode of a small microcontroller: normal run, idle, power-down, a wake-up phase that follows power-down, and an on-circuit emulation mode in which the chip stands aside so that an external tester can drive the board. From the current mode it derives the enables for the CPU clock, the oscillator, the peripheral clocks and the programmable counter array. It also tells the pad ring how to treat the address-latch strobe, the program-store strobe, Port 0 and Port 2.

Software enters idle or power-down through request bits. Idle ends on any enabled pending interrupt. Power-down ends on a device reset or on a level-mode external interrupt line. That exit is a handshake in two steps: the line going low restarts the oscillator, and the line returning high, after a programmable number of machine cycles of oscillator settling, gives the clock back to the CPU. Emulation mode is decoded from the strobe pin levels at the moment the reset pin is released. Every control input is a plain level. No data flows through the block, so it has no valid/ready port.

Top module: `pwrmode_ctrl`

Mode codes on `mode_o`: 0 reset, 1 run, 2 idle, 3 power-down, 4 wake, 5 emulation. Pin-control codes: 0 normal function, 1 drive high, 2 drive low, 3 weak pull-up, 4 float, 5 hold port data, 6 hold address.

## Requirements
- R1: `core_rst` rises only after `rst_pin` has been high across two `mc_tick` pulses. It falls once `rst_pin` is low, and while it is high the mode becomes 0 and stays 0. A shorter reset pulse has no effect.
- R2: In run mode (1), all four clock enables are 1 and all four pin controls are 0.
- R3: In run mode, `idle_req` enters idle (2) and `pd_req` enters power-down (3). If both arrive in the same cycle, power-down wins.
- R4: In idle, `cpu_clk_en` is 0 and `osc_en` and `periph_clk_en` are 1. `pca_clk_en` equals `pca_idle_run`. ALE and PSEN controls are 1 (drive high).
- R5: In idle, `irq_pend` returns the mode to run. `resume_o` is 1 for exactly the first run cycle.
- R6: In power-down with `rst_pin` low, all four clock enables are 0 and the ALE and PSEN controls are 2 (drive low). `irq_pend` is ignored.
- R7: Only an interrupt line whose `int_en` bit is 1, whose `int_lvl` bit is 1 (level mode) and whose `int_n` pin is low starts a wake from power-down. A line that is disabled or in edge mode has no effect.
- R8: A qualifying low line moves power-down to wake (4), where `osc_en` is 1 and `cpu_clk_en` is 0. Wake stays in force while the line stays low. Run is re-entered, with a one-cycle `resume_o`, only after the line has returned high.
- R9: Leaving wake also requires that at least `stab_cnt` `mc_tick` pulses have been counted since wake began. A line released early leaves the CPU clock off until that count is reached.
- R10: In idle and power-down, Port 0 control is 4 (float) when `ext_exec` is 1 and 5 otherwise. Port 2 control is 6 in idle with `ext_exec` 1, and 5 in every other idle or power-down case.
- R11: Emulation mode (5) is entered when `ale_pin` is low and `psen_pin` is high while `core_rst` is high, and `ale_pin` is still low in the cycle the reset ends. Otherwise the reset ends in run mode.
- R12: In emulation mode, Port 0 control is 4 and the ALE, PSEN and Port 2 controls are 3. `osc_en` is 1 and the CPU and peripheral enables are 0.
- R13: Emulation mode is left only through an accepted reset. `idle_req`, `pd_req` and `irq_pend` have no effect in that mode.
- R14: In power-down, `rst_pin` high sets `osc_en` to 1 at once, so that the machine-cycle tick can run and the reset can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous power-on reset of the controller, active low |
| rst_pin | input | 1 | Device reset pin level, active high |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| ale_pin | input | 1 | Sampled level of the address-latch strobe pin |
| psen_pin | input | 1 | Sampled level of the program-store strobe pin |
| idle_req | input | 1 | Idle request from software |
| pd_req | input | 1 | Power-down request from software |
| int_n | input | N_INT | External interrupt pin levels, active low |
| int_en | input | N_INT | Per-line interrupt enable |
| int_lvl | input | N_INT | Per-line level-mode select (1 = level) |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_exec | input | 1 | Code is fetched from external memory |
| pca_idle_run | input | 1 | Keep the counter array running during idle |
| stab_cnt | input | STAB_W | Oscillator settle count in machine cycles |
| core_rst | output | 1 | Qualified reset to the rest of the chip |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pca_clk_en | output | 1 | Counter-array clock enable |
| ale_ctl | output | 3 | ALE pad control code |
| psen_ctl | output | 3 | PSEN pad control code |
| p0_ctl | output | 3 | Port 0 pad control code |
| p2_ctl | output | 3 | Port 2 pad control code |
| resume_o | output | 1 | One-cycle pulse when execution resumes after an interrupt exit |

## Verification
The pad and clock decode is tried with each low-power mode crossed with internal and external execution and with both counter-array idle settings. These combinations separate the Port 0 float case from the hold case, and the Port 2 address case from the data case. Wake is driven with lines that are disabled, in edge mode or fully qualified, which shows that only the qualified line starts a wake. It is also driven with a zero settle count and with a release that comes before the count ends, which shows that the CPU clock waits for both the pin release and the count. Reset is tried with a pulse shorter than two machine cycles and with a full one. Emulation entry is tried with the correct strobe pattern and with the strobe released too early or PSEN held low, which separates the entry from an ordinary reset.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [2:0] {
    PM_RESET = 3'd0,
    PM_RUN   = 3'd1,
    PM_IDLE  = 3'd2,
    PM_PD    = 3'd3,
    PM_WAKE  = 3'd4,
    PM_ONCE  = 3'd5
  } pm_mode_t;

  typedef enum logic [2:0] {
    PC_FUNC      = 3'd0,
    PC_DRV_HI    = 3'd1,
    PC_DRV_LO    = 3'd2,
    PC_WEAK_HI   = 3'd3,
    PC_FLOAT     = 3'd4,
    PC_HOLD_DATA = 3'd5,
    PC_HOLD_ADDR = 3'd6
  } pin_ctl_t;

  typedef struct packed {
    logic osc;
    logic cpu;
    logic per;
    logic pca;
  } clk_en_t;
endpackage

// File: rtl/pm_rst_qual.sv
module pm_rst_qual #(
  parameter int RST_MC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  input  logic mc_tick,
  output logic core_rst
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CW = $clog2(RST_MC + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_MC);

  logic [CW-1:0] held_q;

  // Count machine cycles while the pin stays high; any low drops the count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= '0;
    else if (!rst_pin)
      held_q <= '0;
    else if (mc_tick && held_q != LIM)
      held_q <= held_q + 1'b1;
  end

  assign core_rst = (held_q == LIM);
endmodule

// File: rtl/pm_wake_det.sv
module pm_wake_det #(
  parameter int N_INT = 2
) (
  input  logic [N_INT-1:0] int_n,
  input  logic [N_INT-1:0] int_en,
  input  logic [N_INT-1:0] int_lvl,
  output logic             wake
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [N_INT-1:0] hit;

  for (genvar g = 0; g < N_INT; g++) begin : g_line
    // A line counts only when it is enabled, in level mode and pulled low.
    assign hit[g] = int_en[g] & int_lvl[g] & ~int_n[g];
  end

  assign wake = |hit;
endmodule

// File: rtl/pm_stab_timer.sv
module pm_stab_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear)
      cnt_q <= '0;
    else if (tick && cnt_q < limit)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q >= limit);
endmodule

// File: rtl/pm_pin_ovr.sv
module pm_pin_ovr
  import pwrmode_pkg::*;
(
  input  pm_mode_t   mode,
  input  logic       ext_exec,
  output logic [2:0] ale,
  output logic [2:0] psen,
  output logic [2:0] p0,
  output logic [2:0] p2
);
  timeunit 1ns;
  timeprecision 100ps;

  pin_ctl_t ale_c, psen_c, p0_c, p2_c;

  always_comb begin
    ale_c  = PC_FUNC;
    psen_c = PC_FUNC;
    p0_c   = PC_FUNC;
    p2_c   = PC_FUNC;
    unique case (mode)
      PM_IDLE: begin
        ale_c  = PC_DRV_HI;
        psen_c = PC_DRV_HI;
        p0_c   = ext_exec ? PC_FLOAT : PC_HOLD_DATA;
        p2_c   = ext_exec ? PC_HOLD_ADDR : PC_HOLD_DATA;
      end
      PM_PD, PM_WAKE: begin
        ale_c  = PC_DRV_LO;
        psen_c = PC_DRV_LO;
        p0_c   = ext_exec ? PC_FLOAT : PC_HOLD_DATA;
        p2_c   = PC_HOLD_DATA;
      end
      PM_ONCE: begin
        ale_c  = PC_WEAK_HI;
        psen_c = PC_WEAK_HI;
        p0_c   = PC_FLOAT;
        p2_c   = PC_WEAK_HI;
      end
      default: ;
    endcase
  end

  assign ale  = ale_c;
  assign psen = psen_c;
  assign p0   = p0_c;
  assign p2   = p2_c;
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int N_INT  = 2,
  parameter int STAB_W = 8,
  parameter int RST_MC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin,
  input  logic              mc_tick,
  input  logic              ale_pin,
  input  logic              psen_pin,
  input  logic              idle_req,
  input  logic              pd_req,
  input  logic [N_INT-1:0]  int_n,
  input  logic [N_INT-1:0]  int_en,
  input  logic [N_INT-1:0]  int_lvl,
  input  logic              irq_pend,
  input  logic              ext_exec,
  input  logic              pca_idle_run,
  input  logic [STAB_W-1:0] stab_cnt,
  output logic              core_rst,
  output logic [2:0]        mode_o,
  output logic              cpu_clk_en,
  output logic              osc_en,
  output logic              periph_clk_en,
  output logic              pca_clk_en,
  output logic [2:0]        ale_ctl,
  output logic [2:0]        psen_ctl,
  output logic [2:0]        p0_ctl,
  output logic [2:0]        p2_ctl,
  output logic              resume_o
);
  timeunit 1ns;
  timeprecision 100ps;

  pm_mode_t mode_q, mode_d;
  logic     once_arm_q;
  logic     wake, stab_done, go_resume;
  clk_en_t  ce;

  pm_rst_qual #(.RST_MC(RST_MC)) u_rstq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_pin  (rst_pin),
    .mc_tick  (mc_tick),
    .core_rst (core_rst)
  );

  pm_wake_det #(.N_INT(N_INT)) u_wake (
    .int_n   (int_n),
    .int_en  (int_en),
    .int_lvl (int_lvl),
    .wake    (wake)
  );

  pm_stab_timer #(.W(STAB_W)) u_stab (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (mode_q != PM_WAKE),
    .tick  (mc_tick),
    .limit (stab_cnt),
    .done  (stab_done)
  );

  pm_pin_ovr u_pins (
    .mode     (mode_q),
    .ext_exec (ext_exec),
    .ale      (ale_ctl),
    .psen     (psen_ctl),
    .p0       (p0_ctl),
    .p2       (p2_ctl)
  );

  // Mode sequencing; a qualified reset overrides every other transition.
  always_comb begin
    mode_d    = mode_q;
    go_resume = 1'b0;
    unique case (mode_q)
      PM_RESET: if (!core_rst) mode_d = (once_arm_q && !ale_pin) ? PM_ONCE : PM_RUN;
      PM_RUN: begin
        if (pd_req)        mode_d = PM_PD;
        else if (idle_req) mode_d = PM_IDLE;
      end
      PM_IDLE: if (irq_pend) begin
        mode_d    = PM_RUN;
        go_resume = 1'b1;
      end
      PM_PD: if (wake) mode_d = PM_WAKE;
      PM_WAKE: if (!wake && stab_done) begin
        mode_d    = PM_RUN;
        go_resume = 1'b1;
      end
      PM_ONCE: ;
      default: mode_d = PM_RESET;
    endcase
    if (core_rst) begin
      mode_d    = PM_RESET;
      go_resume = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PM_RESET;
      resume_o <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      resume_o <= go_resume;
    end
  end

  // Emulation entry is armed by the strobe pattern seen during reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      once_arm_q <= 1'b0;
    else if (mode_q == PM_RESET && core_rst) begin
      if (!ale_pin && psen_pin) once_arm_q <= 1'b1;
    end else
      once_arm_q <= 1'b0;
  end

  always_comb begin
    ce = '{osc: 1'b1, cpu: 1'b0, per: 1'b0, pca: 1'b0};
    unique case (mode_q)
      PM_RUN:  ce = '{osc: 1'b1, cpu: 1'b1, per: 1'b1, pca: 1'b1};
      PM_IDLE: ce = '{osc: 1'b1, cpu: 1'b0, per: 1'b1, pca: pca_idle_run};
      PM_PD:   ce = '{osc: rst_pin, cpu: 1'b0, per: 1'b0, pca: 1'b0};
      default: ;
    endcase
  end

  assign mode_o        = mode_q;
  assign osc_en        = ce.osc;
  assign cpu_clk_en    = ce.cpu;
  assign periph_clk_en = ce.per;
  assign pca_clk_en    = ce.pca;
endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_pin,
  input logic       core_rst,
  input logic [2:0] mode_o,
  input logic       cpu_clk_en,
  input logic       osc_en,
  input logic [2:0] ale_ctl,
  input logic [2:0] p0_ctl,
  input logic       resume_o
);
  timeunit 1ns;
  timeprecision 100ps;

  // R1
  rst_forces_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (mode_o == 3'd0));

  // R1
  rst_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> $past(rst_pin));

  // R6
  pd_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && !rst_pin) |-> (!osc_en && !cpu_clk_en));

  // R8
  wake_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4) |-> (osc_en && !cpu_clk_en));

  // R13
  once_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5 && !core_rst) |=> (mode_o == 3'd5));

  // R5
  resume_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> (mode_o == 3'd1 && ($past(mode_o) == 3'd2 || $past(mode_o) == 3'd4)));

  // R12
  once_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5) |-> (p0_ctl == 3'd4 && ale_ctl == 3'd3));
endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_pin    (rst_pin),
  .core_rst   (core_rst),
  .mode_o     (mode_o),
  .cpu_clk_en (cpu_clk_en),
  .osc_en     (osc_en),
  .ale_ctl    (ale_ctl),
  .p0_ctl     (p0_ctl),
  .resume_o   (resume_o)
);

// File: tb/pwrmode_ctrl_bench.sv
module pwrmode_ctrl_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_pin = 1'b0;
  logic       mc_tick = 1'b0;
  logic       ale_pin = 1'b1;
  logic       psen_pin = 1'b1;
  logic       idle_req = 1'b0;
  logic       pd_req = 1'b0;
  logic [1:0] int_n = 2'b11;
  logic [1:0] int_en = 2'b00;
  logic [1:0] int_lvl = 2'b00;
  logic       irq_pend = 1'b0;
  logic       ext_exec = 1'b0;
  logic       pca_idle_run = 1'b0;
  logic [7:0] stab_cnt = 8'd0;
  logic       core_rst, cpu_clk_en, osc_en, periph_clk_en, pca_clk_en, resume_o;
  logic [2:0] mode_o, ale_ctl, psen_ctl, p0_ctl, p2_ctl;

  int n_chk = 0;
  int n_err = 0;
  logic [1:0] tick_div = 2'd0;

  always #2.5 clk = ~clk;

  // One machine-cycle tick every four clocks.
  always @(posedge clk) begin
    tick_div <= tick_div + 2'd1;
    mc_tick  <= (tick_div == 2'd3);
  end

  pwrmode_ctrl u_pwrmode_ctrl (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .mc_tick(mc_tick),
    .ale_pin(ale_pin), .psen_pin(psen_pin), .idle_req(idle_req), .pd_req(pd_req),
    .int_n(int_n), .int_en(int_en), .int_lvl(int_lvl), .irq_pend(irq_pend),
    .ext_exec(ext_exec), .pca_idle_run(pca_idle_run), .stab_cnt(stab_cnt),
    .core_rst(core_rst), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .periph_clk_en(periph_clk_en), .pca_clk_en(pca_clk_en), .ale_ctl(ale_ctl),
    .psen_ctl(psen_ctl), .p0_ctl(p0_ctl), .p2_ctl(p2_ctl), .resume_o(resume_o)
  );

  // {op(0 idle,1 pd), ext_exec, pca_idle_run, osc cpu per pca, ale, psen, p0, p2}
  localparam logic [18:0] VEC [5] = '{
    {1'b0, 1'b0, 1'b0, 4'b1010, 3'd1, 3'd1, 3'd5, 3'd5},
    {1'b0, 1'b1, 1'b1, 4'b1011, 3'd1, 3'd1, 3'd4, 3'd6},
    {1'b0, 1'b0, 1'b1, 4'b1011, 3'd1, 3'd1, 3'd5, 3'd5},
    {1'b1, 1'b0, 1'b0, 4'b0000, 3'd2, 3'd2, 3'd5, 3'd5},
    {1'b1, 1'b1, 1'b1, 4'b0000, 3'd2, 3'd2, 3'd4, 3'd5}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_reset(input logic ale_rel);
    rst_pin = 1'b1;
    cyc(14);
    ale_pin = ale_rel;
    cyc(1);
    rst_pin = 1'b0;
    cyc(3);
  endtask

  task automatic pulse_req(input logic pd);
    if (pd) pd_req = 1'b1; else idle_req = 1'b1;
    cyc(1);
    pd_req = 1'b0;
    idle_req = 1'b0;
  endtask

  initial begin
    #750000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1: full reset pulse, check during and after
    rst_pin = 1'b1;
    cyc(14);
    chk("R1 core_rst held", core_rst, 1);
    chk("R1 mode in reset", mode_o, 0);
    rst_pin = 1'b0;
    cyc(3);
    chk("R1 core_rst released", core_rst, 0);
    // R2: run state outputs
    chk("R2 mode run", mode_o, 1);
    chk("R2 clocks", {osc_en, cpu_clk_en, periph_clk_en, pca_clk_en}, 4'b1111);
    chk("R2 pins", {ale_ctl, psen_ctl, p0_ctl, p2_ctl}, 0);

    // R1: pulse shorter than two machine cycles is not accepted
    rst_pin = 1'b1;
    cyc(3);
    chk("R1 short pulse core_rst", core_rst, 0);
    rst_pin = 1'b0;
    cyc(2);
    chk("R1 short pulse mode", mode_o, 1);

    // Table walk: R3 R4 R6 R10 R5 R14
    for (int i = 0; i < 5; i++) begin
      logic [18:0] v;
      v = VEC[i];
      ext_exec = v[17];
      pca_idle_run = v[16];
      cyc(1);
      pulse_req(v[18]);
      chk($sformatf("R3 vec%0d mode", i), mode_o, v[18] ? 3 : 2);
      chk($sformatf("R4/R6 vec%0d clocks", i),
          {osc_en, cpu_clk_en, periph_clk_en, pca_clk_en}, v[15:12]);
      chk($sformatf("R4/R6 vec%0d ale/psen", i), {ale_ctl, psen_ctl}, v[11:6]);
      chk($sformatf("R10 vec%0d p0/p2", i), {p0_ctl, p2_ctl}, v[5:0]);
      if (!v[18]) begin
        irq_pend = 1'b1;
        cyc(1);
        irq_pend = 1'b0;
        chk($sformatf("R5 vec%0d mode run", i), mode_o, 1);
        chk($sformatf("R5 vec%0d resume", i), resume_o, 1);
        cyc(1);
        chk($sformatf("R5 vec%0d resume one cycle", i), resume_o, 0);
      end else begin
        irq_pend = 1'b1;
        cyc(2);
        irq_pend = 1'b0;
        chk($sformatf("R6 vec%0d irq ignored", i), mode_o, 3);
        rst_pin = 1'b1;
        #1;
        chk($sformatf("R14 vec%0d osc on reset", i), osc_en, 1);
        cyc(14);
        rst_pin = 1'b0;
        cyc(3);
        chk($sformatf("R14 vec%0d back to run", i), mode_o, 1);
      end
    end
    ext_exec = 1'b0;
    pca_idle_run = 1'b0;

    // R3: power-down wins over idle
    idle_req = 1'b1;
    pd_req = 1'b1;
    cyc(1);
    idle_req = 1'b0;
    pd_req = 1'b0;
    chk("R3 pd priority", mode_o, 3);

    // R7: edge-mode and disabled lines are ignored
    int_en = 2'b11; int_lvl = 2'b01; int_n = 2'b01;
    cyc(3);
    chk("R7 edge-mode line ignored", mode_o, 3);
    chk("R7 osc stays off", osc_en, 0);
    int_en = 2'b10; int_lvl = 2'b11; int_n = 2'b10;
    cyc(3);
    chk("R7 disabled line ignored", mode_o, 3);
    int_n = 2'b11;

    // R8: two-phase exit with zero settle count
    int_en = 2'b01; int_lvl = 2'b01; stab_cnt = 8'd0;
    int_n = 2'b10;
    cyc(1);
    chk("R8 wake mode", mode_o, 4);
    chk("R8 osc on cpu off", {osc_en, cpu_clk_en}, 2'b10);
    cyc(10);
    chk("R8 held low stays wake", mode_o, 4);
    int_n = 2'b11;
    cyc(1);
    chk("R8 release to run", mode_o, 1);
    chk("R8 resume pulse", resume_o, 1);
    chk("R8 cpu clock back", cpu_clk_en, 1);

    // R9: early release waits for settle count
    stab_cnt = 8'd5;
    pulse_req(1'b1);
    int_n = 2'b10;
    cyc(1);
    int_n = 2'b11;
    cyc(2);
    chk("R9 early release still wake", mode_o, 4);
    chk("R9 cpu still off", cpu_clk_en, 0);
    cyc(40);
    chk("R9 run after count", mode_o, 1);
    stab_cnt = 8'd0;

    // R11/R12/R13: emulation entry, pins, stickiness
    ale_pin = 1'b0;
    psen_pin = 1'b1;
    pin_reset(1'b0);
    chk("R11 enter emulation", mode_o, 5);
    chk("R12 pins", {ale_ctl, psen_ctl, p0_ctl, p2_ctl}, {3'd3, 3'd3, 3'd4, 3'd3});
    chk("R12 clocks", {osc_en, cpu_clk_en, periph_clk_en}, 3'b100);
    ale_pin = 1'b1;
    pulse_req(1'b0);
    pulse_req(1'b1);
    irq_pend = 1'b1;
    cyc(2);
    irq_pend = 1'b0;
    chk("R13 requests ignored", mode_o, 5);
    pin_reset(1'b1);
    chk("R13 reset leaves emulation", mode_o, 1);

    // R11 negatives: ALE released early; PSEN low
    ale_pin = 1'b0;
    pin_reset(1'b1);
    chk("R11 ale released early", mode_o, 1);
    ale_pin = 1'b0;
    psen_pin = 1'b0;
    pin_reset(1'b0);
    chk("R11 psen low", mode_o, 1);
    ale_pin = 1'b1;
    psen_pin = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule